// File: doc/BRIEF.md
# Two-level translation table walker

This block turns a 32-bit device address into a physical address by fetching descriptors from memory-resident translation tables. A caller presents a device address together with a first-level table base. The walker reads one 32-bit first-level descriptor. If that descriptor points at a second-level table, it reads one second-level descriptor as well. It then returns the physical address, a page size code and a fault flag.

Four mapping granules are decoded: 4 KB and 64 KB pages from second-level tables, and 1 MB and 16 MB regions from the first level. The 16 MB and 64 KB mappings occupy sixteen identical consecutive slots in their tables. Because of this, any of the sixteen copies yields the same translation, as long as the offset mask for the granule is applied. Memory is reached through a request channel with valid/ready and a response channel carrying a valid strobe. The result stays on the outputs until the caller acknowledges it, and only then is a new request taken.

Top module: `tw_walker`

## Requirements
- R1: After reset the walker is idle: `req_ready_o` is 1, and `res_valid_o` and `mem_req_valid_o` are 0.
- R2: The first read of a translation is at address {base[31:14], va[31:20], 2'b00}, so the base is taken as aligned to 16 KB.
- R3: A first-level descriptor with low bits 10 and bit 18 clear is a 1 MB section. The result is pa = {desc[31:20], va[19:0]} with size code 2.
- R4: A first-level descriptor with low bits 10 and bit 18 set is a 16 MB supersection. The result is pa = {desc[31:24], va[23:0]} with size code 3, and the same value comes back for an address in any of its sixteen slots.
- R5: A first-level descriptor with low bits 01 points at a 1 KB aligned second-level table. The second read is at {desc[31:10], va[19:12], 2'b00}.
- R6: A second-level descriptor with bit 1 set (low bits 10 or 11) is a 4 KB page. The result is pa = {desc[31:12], va[11:0]} with size code 0.
- R7: A second-level descriptor with low bits 01 is a 64 KB page. The result is pa = {desc[31:16], va[15:0]} with size code 1.
- R8: A first-level descriptor with low bits 00 or 11, or a second-level descriptor with low bits 00, gives `res_fault_o` = 1 with `res_pa_o` equal to the faulting device address and size code 0.
- R9: A translation issues exactly one memory read when it ends at the first level and exactly two when it goes through a second-level table. No read is issued while a result is pending.
- R10: The result outputs stay valid and unchanged until `res_ack_i`. While the walker is busy, `req_ready_o` is 0 and a presented request is ignored.
- R11: While a memory request is stalled by `mem_req_ready_i` = 0, `mem_req_valid_o` stays 1 and `mem_req_addr_o` stays unchanged.
- R12: With memory accepting at once and answering in L cycles, the result is valid 1 + n*(1+L) clock edges after the accepting edge, where n is the number of reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| base_i | input | 32 | First-level table base, sampled when a request is accepted |
| req_valid_i | input | 1 | Translate request present |
| req_ready_o | output | 1 | Walker idle, request accepted on this edge |
| req_addr_i | input | 32 | Device address to translate |
| mem_req_valid_o | output | 1 | Descriptor read request |
| mem_req_ready_i | input | 1 | Memory accepts the read |
| mem_req_addr_o | output | 32 | Byte address of the descriptor |
| mem_rsp_valid_i | input | 1 | Read data valid |
| mem_rsp_data_i | input | 32 | Descriptor read from memory |
| res_valid_o | output | 1 | Translation result valid |
| res_ack_i | input | 1 | Caller takes the result |
| res_pa_o | output | 32 | Physical address, or device address on a fault |
| res_size_o | output | 2 | Granule: 0 = 4 KB, 1 = 64 KB, 2 = 1 MB, 3 = 16 MB |
| res_fault_o | output | 1 | Translation fault |

## Verification
With a memory that accepts at once and answers L cycles after the handshake, a one-read walk must show its result 1 + (1+L) edges after the accepting edge, and a two-read walk 1 + 2(1+L) edges after it. The bench drives requests on the falling edge and counts falling edges from the acceptance until `res_valid_o` appears, then compares that count with the formula for latencies of 1 and 3. A stall scenario with the ready input held low lengthens the walk by an unknown amount, so it checks values only. Held-result and ignored-request checks sample the ports on falling edges during the hold.

// File: rtl/tw_pkg.sv
package tw_pkg;
  localparam int AW      = 32;
  localparam int DW      = 32;
  localparam int L1_LSB  = 20;
  localparam int L1_BW   = AW - L1_LSB;
  localparam int L2_LSB  = 12;
  localparam int L2_BW   = L1_LSB - L2_LSB;
  localparam int BASE_LSB = L1_BW + 2;
  localparam int TBL_LSB  = L2_BW + 2;
  localparam int SUPER_BIT = 18;
  localparam int SZ_W    = 2;

  typedef enum logic [SZ_W-1:0] {
    SZ_4K  = 2'd0,
    SZ_64K = 2'd1,
    SZ_1M  = 2'd2,
    SZ_16M = 2'd3
  } size_e;

  typedef enum logic [1:0] {
    K_FAULT = 2'd0,
    K_TABLE = 2'd1,
    K_SECT  = 2'd2,
    K_SUPER = 2'd3
  } l1_kind_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_L1_REQ, ST_L1_WAIT, ST_L2_REQ, ST_L2_WAIT, ST_DONE
  } state_e;
endpackage

// File: rtl/tw_rst_sync.sv
module tw_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/tw_l1_dec.sv
module tw_l1_dec
  import tw_pkg::*;
(
  input  logic [DW-1:0] desc_i,
  input  logic [AW-1:0] va_i,
  output l1_kind_e      kind_o,
  output logic [AW-1:0] pa_o,
  output size_e         size_o,
  output logic [AW-1:0] l2_addr_o
);
  always_comb begin
    unique case (desc_i[1:0])
      2'b01:   kind_o = K_TABLE;
      2'b10:   kind_o = desc_i[SUPER_BIT] ? K_SUPER : K_SECT;
      default: kind_o = K_FAULT;
    endcase
  end

  always_comb begin
    if (kind_o == K_SUPER) begin
      pa_o   = {desc_i[AW-1:24], va_i[23:0]};
      size_o = SZ_16M;
    end else begin
      pa_o   = {desc_i[AW-1:L1_LSB], va_i[L1_LSB-1:0]};
      size_o = SZ_1M;
    end
  end

  assign l2_addr_o = {desc_i[AW-1:TBL_LSB], va_i[L1_LSB-1:L2_LSB], 2'b00};
endmodule

// File: rtl/tw_l2_dec.sv
module tw_l2_dec
  import tw_pkg::*;
(
  input  logic [DW-1:0] desc_i,
  input  logic [AW-1:0] va_i,
  output logic          fault_o,
  output logic [AW-1:0] pa_o,
  output size_e         size_o
);
  always_comb begin
    fault_o = 1'b0;
    if (desc_i[1]) begin
      pa_o   = {desc_i[AW-1:L2_LSB], va_i[L2_LSB-1:0]};
      size_o = SZ_4K;
    end else if (desc_i[0]) begin
      pa_o   = {desc_i[AW-1:16], va_i[15:0]};
      size_o = SZ_64K;
    end else begin
      fault_o = 1'b1;
      pa_o    = va_i;
      size_o  = SZ_4K;
    end
  end
endmodule

// File: rtl/tw_walker.sv
module tw_walker
  import tw_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] base_i,
  input  logic          req_valid_i,
  output logic          req_ready_o,
  input  logic [AW-1:0] req_addr_i,
  output logic          mem_req_valid_o,
  input  logic          mem_req_ready_i,
  output logic [AW-1:0] mem_req_addr_o,
  input  logic          mem_rsp_valid_i,
  input  logic [DW-1:0] mem_rsp_data_i,
  output logic          res_valid_o,
  input  logic          res_ack_i,
  output logic [AW-1:0] res_pa_o,
  output logic [1:0]    res_size_o,
  output logic          res_fault_o
);
  logic          rst_sync_n;
  state_e        st_q, st_d;
  logic [AW-1:0] va_q, addr_q, addr_d, pa_q, pa_d;
  size_e         sz_q, sz_d;
  logic          flt_q, flt_d;
  logic          va_en, addr_en, res_en;

  l1_kind_e      l1_kind;
  logic [AW-1:0] l1_pa, l1_l2_addr, l2_pa;
  size_e         l1_sz, l2_sz;
  logic          l2_fault;

  tw_rst_sync i_rst_sync (.clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n));

  tw_l1_dec i_l1_dec (
    .desc_i(mem_rsp_data_i), .va_i(va_q), .kind_o(l1_kind),
    .pa_o(l1_pa), .size_o(l1_sz), .l2_addr_o(l1_l2_addr)
  );

  tw_l2_dec i_l2_dec (
    .desc_i(mem_rsp_data_i), .va_i(va_q), .fault_o(l2_fault),
    .pa_o(l2_pa), .size_o(l2_sz)
  );

  always_comb begin
    st_d    = st_q;
    addr_d  = addr_q;
    pa_d    = pa_q;
    sz_d    = sz_q;
    flt_d   = flt_q;
    va_en   = 1'b0;
    addr_en = 1'b0;
    res_en  = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (req_valid_i) begin
          st_d    = ST_L1_REQ;
          va_en   = 1'b1;
          addr_en = 1'b1;
          addr_d  = {base_i[AW-1:BASE_LSB], req_addr_i[AW-1:L1_LSB], 2'b00};
        end
      end
      ST_L1_REQ: if (mem_req_ready_i) st_d = ST_L1_WAIT;
      ST_L1_WAIT: begin
        if (mem_rsp_valid_i) begin
          if (l1_kind == K_TABLE) begin
            st_d    = ST_L2_REQ;
            addr_en = 1'b1;
            addr_d  = l1_l2_addr;
          end else begin
            st_d   = ST_DONE;
            res_en = 1'b1;
            if (l1_kind == K_FAULT) begin
              pa_d  = va_q;
              sz_d  = SZ_4K;
              flt_d = 1'b1;
            end else begin
              pa_d  = l1_pa;
              sz_d  = l1_sz;
              flt_d = 1'b0;
            end
          end
        end
      end
      ST_L2_REQ: if (mem_req_ready_i) st_d = ST_L2_WAIT;
      ST_L2_WAIT: begin
        if (mem_rsp_valid_i) begin
          st_d   = ST_DONE;
          res_en = 1'b1;
          pa_d   = l2_pa;
          sz_d   = l2_sz;
          flt_d  = l2_fault;
        end
      end
      ST_DONE: if (res_ack_i) st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) st_q <= ST_IDLE;
    else             st_q <= st_d;
  end

  always_ff @(posedge clk) begin
    if (va_en)   va_q   <= req_addr_i;
    if (addr_en) addr_q <= addr_d;
    if (res_en) begin
      pa_q  <= pa_d;
      sz_q  <= sz_d;
      flt_q <= flt_d;
    end
  end

  assign req_ready_o     = (st_q == ST_IDLE);
  assign mem_req_valid_o = (st_q == ST_L1_REQ) || (st_q == ST_L2_REQ);
  assign mem_req_addr_o  = addr_q;
  assign res_valid_o     = (st_q == ST_DONE);
  assign res_pa_o        = pa_q;
  assign res_size_o      = sz_q;
  assign res_fault_o     = flt_q;
endmodule

// File: rtl/tw_walker_chk.sv
module tw_walker_chk
  import tw_pkg::*;
(
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid_i,
  input logic          req_ready_o,
  input logic [AW-1:0] req_addr_i,
  input logic          mem_req_valid_o,
  input logic          mem_req_ready_i,
  input logic [AW-1:0] mem_req_addr_o,
  input logic          res_valid_o,
  input logic          res_ack_i,
  input logic [AW-1:0] res_pa_o,
  input logic [1:0]    res_size_o,
  input logic          res_fault_o
);
  logic [AW-1:0] va_cap;
  logic [2:0]    rd_cnt;
  logic [AW-1:0] off_mask;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      va_cap <= '0;
      rd_cnt <= '0;
    end else if (req_valid_i && req_ready_o) begin
      va_cap <= req_addr_i;
      rd_cnt <= '0;
    end else if (mem_req_valid_o && mem_req_ready_i && rd_cnt != 3'd7) begin
      rd_cnt <= rd_cnt + 3'd1;
    end
  end

  always_comb begin
    unique case (res_size_o)
      2'd0:    off_mask = 32'h0000_0FFF;
      2'd1:    off_mask = 32'h0000_FFFF;
      2'd2:    off_mask = 32'h000F_FFFF;
      default: off_mask = 32'h00FF_FFFF;
    endcase
  end

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid_o && !mem_req_ready_i |=> mem_req_valid_o && $stable(mem_req_addr_o)); // R11

  AST_RES_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid_o && !res_ack_i |=> res_valid_o && $stable(res_pa_o) && $stable(res_size_o) && $stable(res_fault_o)); // R10

  AST_BUSY_NO_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid_o || res_valid_o) |-> !req_ready_o); // R10

  AST_READ_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    rd_cnt <= 3'd2); // R9

  AST_NO_READ_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid_o |-> !mem_req_valid_o); // R9

  AST_FAULT_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid_o && res_fault_o |-> res_pa_o == va_cap && res_size_o == 2'd0); // R8

  AST_OFFSET_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid_o && !res_fault_o |-> (res_pa_o & off_mask) == (va_cap & off_mask)); // R3 R4 R6 R7
endmodule

bind tw_walker tw_walker_chk i_tw_walker_chk (.*);

// File: tb/test_tw_walker.sv
module test_tw_walker;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] BASE = 32'h0004_C000;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] base_i;
  logic        req_valid_i;
  logic        req_ready_o;
  logic [31:0] req_addr_i;
  logic        mem_req_valid_o;
  logic        mem_req_ready_i;
  logic [31:0] mem_req_addr_o;
  logic        mem_rsp_valid_i;
  logic [31:0] mem_rsp_data_i;
  logic        res_valid_o;
  logic        res_ack_i;
  logic [31:0] res_pa_o;
  logic [1:0]  res_size_o;
  logic        res_fault_o;

  int checks = 0;
  int errors = 0;

  logic [31:0] mem [int unsigned];
  int          lat = 1;
  int          cnt = 0;
  logic [31:0] paddr;
  int          reads = 0;
  logic [31:0] rd_addr [2];

  always #(CLK_PERIOD/2) clk = ~clk;

  tw_walker i_tw_walker (.*);

  function automatic logic [31:0] rd(input logic [31:0] a);
    if (mem.exists(a)) return mem[a];
    return 32'h0;
  endfunction

  always @(posedge clk) begin
    mem_rsp_valid_i <= 1'b0;
    if (cnt > 0) begin
      cnt <= cnt - 1;
      if (cnt == 1) begin
        mem_rsp_valid_i <= 1'b1;
        mem_rsp_data_i  <= rd(paddr);
      end
    end else if (mem_req_valid_o && mem_req_ready_i) begin
      if (reads < 2) rd_addr[reads] <= mem_req_addr_o;
      reads <= reads + 1;
      if (lat == 1) begin
        mem_rsp_valid_i <= 1'b1;
        mem_rsp_data_i  <= rd(mem_req_addr_o);
      end else begin
        cnt   <= lat - 1;
        paddr <= mem_req_addr_o;
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic translate(input string tag, input logic [31:0] va, input int l,
                           input logic [31:0] e_pa, input logic [1:0] e_sz,
                           input logic e_flt, input int e_reads,
                           input logic [31:0] e_a1, input logic [31:0] e_a2,
                           input bit time_chk);
    int cyc;
    lat = l;
    @(negedge clk);
    reads = 0;
    req_valid_i = 1'b1;
    req_addr_i  = va;
    chk({tag, " R10 ready when idle"}, {31'd0, req_ready_o}, 32'd1);
    @(posedge clk);
    @(negedge clk);
    req_valid_i = 1'b0;
    cyc = 1;
    while (!res_valid_o && cyc < 100) begin
      @(negedge clk);
      cyc++;
    end
    if (time_chk)
      chk({tag, " R12 result cycle"}, cyc, 1 + e_reads * (1 + l));
    chk({tag, " pa"}, res_pa_o, e_pa);
    chk({tag, " size"}, {30'd0, res_size_o}, {30'd0, e_sz});
    chk({tag, " R8 fault"}, {31'd0, res_fault_o}, {31'd0, e_flt});
    chk({tag, " R9 reads"}, reads, e_reads);
    chk({tag, " R2 first read addr"}, rd_addr[0], e_a1);
    if (e_reads == 2) chk({tag, " R5 second read addr"}, rd_addr[1], e_a2);
    res_ack_i = 1'b1;
    @(negedge clk);
    res_ack_i = 1'b0;
    chk({tag, " R10 released after ack"}, {30'd0, res_valid_o, req_ready_o}, 32'd1);
  endtask

  function automatic logic [31:0] l1a(input logic [31:0] va);
    return {BASE[31:14], va[31:20], 2'b00};
  endfunction

  task automatic t_reset;
    chk("R1 req_ready after reset", {31'd0, req_ready_o}, 32'd1);
    chk("R1 res_valid after reset", {31'd0, res_valid_o}, 32'd0);
    chk("R1 mem_req_valid after reset", {31'd0, mem_req_valid_o}, 32'd0);
  endtask

  task automatic t_section;
    translate("R3 section", 32'h0034_5678, 1, 32'h8124_5678, 2'd2, 1'b0, 1,
              l1a(32'h0034_5678), 32'h0, 1'b1);
  endtask

  task automatic t_super;
    translate("R4 supersection slot7", 32'h0A7B_CDEF, 1, 32'h9B7B_CDEF, 2'd3, 1'b0, 1,
              l1a(32'h0A7B_CDEF), 32'h0, 1'b1);
    translate("R4 supersection slot0", 32'h0A01_2345, 3, 32'h9B01_2345, 2'd3, 1'b0, 1,
              l1a(32'h0A01_2345), 32'h0, 1'b1);
    translate("R4 supersection slot15", 32'h0AF0_0001, 1, 32'h9BF0_0001, 2'd3, 1'b0, 1,
              l1a(32'h0AF0_0001), 32'h0, 1'b1);
  endtask

  task automatic t_small;
    translate("R6 small 10", 32'h0102_3ABC, 1, 32'h5555_6ABC, 2'd0, 1'b0, 2,
              l1a(32'h0102_3ABC), 32'h0007_048C, 1'b1);
    translate("R6 small 11", 32'h0102_4001, 3, 32'h4444_7001, 2'd0, 1'b0, 2,
              l1a(32'h0102_4001), 32'h0007_0490, 1'b1);
  endtask

  task automatic t_large;
    translate("R7 large slot9", 32'h0104_9876, 1, 32'h7777_9876, 2'd1, 1'b0, 2,
              l1a(32'h0104_9876), 32'h0007_0524, 1'b1);
    translate("R7 large slot0", 32'h0104_0FF0, 1, 32'h7777_0FF0, 2'd1, 1'b0, 2,
              l1a(32'h0104_0FF0), 32'h0007_0500, 1'b1);
  endtask

  task automatic t_faults;
    translate("R8 L1 zero", 32'h0200_1234, 1, 32'h0200_1234, 2'd0, 1'b1, 1,
              l1a(32'h0200_1234), 32'h0, 1'b1);
    translate("R8 L1 type11", 32'h0210_0000, 1, 32'h0210_0000, 2'd0, 1'b1, 1,
              l1a(32'h0210_0000), 32'h0, 1'b1);
    translate("R8 L2 zero", 32'h0106_0ABC, 1, 32'h0106_0ABC, 2'd0, 1'b1, 2,
              l1a(32'h0106_0ABC), 32'h0007_0580, 1'b1);
  endtask

  task automatic t_stall;
    fork
      translate("R11 stalled memory", 32'h0102_3004, 2, 32'h5555_6004, 2'd0, 1'b0, 2,
                l1a(32'h0102_3004), 32'h0007_048C, 1'b0);
      begin
        @(negedge clk);
        mem_req_ready_i = 1'b0;
        repeat (4) @(negedge clk);
        mem_req_ready_i = 1'b1;
        repeat (4) @(negedge clk);
        mem_req_ready_i = 1'b0;
        repeat (3) @(negedge clk);
        mem_req_ready_i = 1'b1;
      end
    join
  endtask

  task automatic t_hold;
    int rd_before;
    lat = 1;
    @(negedge clk);
    reads = 0;
    req_valid_i = 1'b1;
    req_addr_i  = 32'h0034_0001;
    @(negedge clk);
    req_addr_i  = 32'h0A00_0000;
    while (!res_valid_o) @(negedge clk);
    rd_before = reads;
    repeat (5) @(negedge clk);
    chk("R10 held valid", {31'd0, res_valid_o}, 32'd1);
    chk("R10 held pa", res_pa_o, 32'h8124_0001);
    chk("R10 request ignored while busy", {31'd0, req_ready_o}, 32'd0);
    chk("R9 no read while pending", reads, rd_before);
    req_valid_i = 1'b0;
    res_ack_i = 1'b1;
    @(negedge clk);
    res_ack_i = 1'b0;
    chk("R10 idle after ack", {31'd0, req_ready_o}, 32'd1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    base_i = BASE;
    req_valid_i = 1'b0;
    req_addr_i = '0;
    mem_req_ready_i = 1'b1;
    res_ack_i = 1'b0;
    mem_rsp_data_i = '0;
    rd_addr[0] = '0;
    rd_addr[1] = '0;
    mem[l1a(32'h0030_0000)] = 32'h8120_0002;
    for (int i = 0; i < 16; i++) mem[l1a(32'h0A00_0000) + 4*i] = 32'h9B04_0002;
    mem[l1a(32'h0100_0000)] = 32'h0007_0401;
    mem[32'h0007_048C] = 32'h5555_6002;
    mem[32'h0007_0490] = 32'h4444_7003;
    for (int i = 0; i < 16; i++) mem[32'h0007_0500 + 4*i] = 32'h7777_0001;
    mem[l1a(32'h0210_0000)] = 32'h1234_0003;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_section();
    t_super();
    t_small();
    t_large();
    t_faults();
    t_stall();
    t_hold();
    repeat (3) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule